// File: doc/BRIEF.md
# SPI Register-File Slave

This block is a four-wire serial slave that gives an external SPI master read and write access to a bank of 64 byte-wide registers. The master pulls the active-low select low, toggles the serial clock and shifts one command byte, then one or more data bytes. The first command bit picks the direction. The second picks whether the register address steps forward after each data byte. The last six bits name the first register. The serial clock rests high while the select is high. Input data is taken on rising serial-clock edges and output data is changed on falling edges.

The slave runs on an oversampling system clock. Select, serial clock and input data pass through a synchronizer with a parameter-chosen number of stages. Zero stages are allowed for inputs that are already synchronous to the system clock. The engine then turns serial-clock transitions into one-cycle edge events.

Inside the block, the register bank has a write strobe and a combinational read port. The output-enable pin tells the pad when to drive the shared data-out line. Read data starts on the falling edge that opens bit 8, which is the first data bit.

Top module: `spi_rf_slave`

## Requirements
- R1: After reset, sdo_oe is 0 and every register reads back as 0x00.
- R2: The command byte is sent MSB first. Bit 7 is the direction (0 = write, 1 = read), bit 6 is the step flag, and bits 5..0 are the register address. sdo_oe stays 0 for the whole command byte.
- R3: In a write, each data byte is stored in the addressed register once its 8th bit has been taken on a rising edge. sdo_oe stays 0 throughout.
- R4: In a read, sdo_oe rises on the falling edge that starts bit 8. Each data byte then appears on sdo MSB first.
- R5: With the step flag set to 1, the address increases by one after every data byte, in both reads and writes.
- R6: With the step flag set to 0, every data byte uses the same address. A multi-byte write leaves the last byte in that register, and a multi-byte read repeats the same value.
- R7: A stepping address wraps from 63 to 0.
- R8: If the select rises before all 8 bits of a data byte have arrived, that partial byte is dropped and no register changes.
- R9: sdo changes only on falling serial-clock edges, so it holds its value across each rising edge.
- R10: sdo_oe returns to 0 once the select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| spc | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial data to master, valid while sdo_oe is 1 |
| sdo_oe | output | 1 | Drive enable for the sdo pad |

## Verification
Every serial-clock edge reaches the engine after the synchronizer depth plus one edge-detect cycle.

- sdo and sdo_oe settle about four system clocks after the falling edge that caused them.
- A register write lands about four clocks after the 8th rising edge of its byte.

The bench holds each serial-clock phase for eight system clocks and samples only at the end of a phase. Each phase is therefore longer than every latency above. Expected read bytes are queued before their bits are clocked. A monitor gathers sdo on every rising edge while it is enabled and compares each full byte with the head of the queue.

// File: rtl/spi_rf_pkg.sv
`timescale 1ns/1ps
package spi_rf_pkg;
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic active;
   } spc_evt_t;
endpackage

// File: rtl/spi_rf_sync.sv
`timescale 1ns/1ps
module spi_rf_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("spi_rf_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_rf_edge.sv
`timescale 1ns/1ps
module spi_rf_edge
   import spi_rf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cs_s,
   input  logic     spc_s,
   output spc_evt_t evt
);
   logic spc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spc_q <= 1'b1;
      else        spc_q <= spc_s;
   end

   always_comb begin
      evt.active = ~cs_s;
      evt.rise   = ~cs_s &  spc_s & ~spc_q;
      evt.fall   = ~cs_s & ~spc_s &  spc_q;
   end
endmodule

// File: rtl/spi_rf_regbank.sv
`timescale 1ns/1ps
module spi_rf_regbank #(
   parameter int                ADDR_W  = 6,
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH > 1024) begin : g_bad_depth
      $error("spi_rf_regbank: ADDR_W too large");
   end

   logic [DATA_W-1:0] rd_vec [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                        q <= RST_VAL;
         else if (wr_en && wr_addr == ADDR_W'(i))           q <= wr_data;
      end
      assign rd_vec[i] = q;
   end

   assign rd_data = rd_vec[rd_addr];

   // R3
   reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_vec[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spi_rf_engine.sv
`timescale 1ns/1ps
module spi_rf_engine
   import spi_rf_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sdi_s,
   input  spc_evt_t          evt,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int BIT_W = $clog2(DATA_W);

   logic [BIT_W-1:0]  bit_idx;
   logic              in_data;
   xfer_dir_e         dir_q;
   logic              inc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] shift_in;
   logic [DATA_W-1:0] tx_sh;
   logic              oe_q;
   logic              last_bit;
   logic [DATA_W-1:0] byte_now;

   assign last_bit = (bit_idx == BIT_W'(DATA_W-1));
   assign byte_now = {shift_in[DATA_W-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx  <= '0;
         in_data  <= 1'b0;
         dir_q    <= XFER_WRITE;
         inc_q    <= 1'b0;
         addr_q   <= '0;
         shift_in <= '0;
         tx_sh    <= '0;
         oe_q     <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else if (!evt.active) begin
         bit_idx <= '0;
         in_data <= 1'b0;
         oe_q    <= 1'b0;
         wr_en   <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (evt.rise) begin
            shift_in <= byte_now;
            bit_idx  <= last_bit ? '0 : bit_idx + BIT_W'(1);
            if (last_bit) begin
               if (!in_data) begin
                  dir_q   <= xfer_dir_e'(byte_now[DATA_W-1]);
                  inc_q   <= byte_now[DATA_W-2];
                  addr_q  <= byte_now[ADDR_W-1:0];
                  in_data <= 1'b1;
               end else begin
                  if (dir_q == XFER_WRITE) begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= byte_now;
                  end
                  if (inc_q) addr_q <= addr_q + ADDR_W'(1);
               end
            end
         end
         if (evt.fall && in_data && dir_q == XFER_READ) begin
            if (bit_idx == '0) begin
               tx_sh <= rd_data;
               oe_q  <= 1'b1;
            end else begin
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rd_addr = addr_q;
   assign sdo     = oe_q & tx_sh[DATA_W-1];
   assign sdo_oe  = oe_q;

   // R2
   oe_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data |-> !oe_q);
   // R10
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !oe_q);
   // R3
   wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> dir_q == XFER_WRITE);
   // R7
   addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rise && in_data && last_bit && inc_q && addr_q == '1) |=> addr_q == '0);
   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rise && in_data && last_bit && !inc_q) |=> $stable(addr_q));
   // R9
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !evt.fall) |=> $stable(tx_sh));
endmodule

// File: rtl/spi_rf_slave.sv
`timescale 1ns/1ps
module spi_rf_slave
   import spi_rf_pkg::*;
#(
   parameter int                ADDR_W      = 6,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RST_VAL     = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic spc,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   if (ADDR_W + 2 != DATA_W) begin : g_bad_frame
      $error("spi_rf_slave: command must fit one frame (ADDR_W + 2 == DATA_W)");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("spi_rf_slave: DATA_W must be at least 4");
   end

   logic [2:0]        pins_s;
   spc_evt_t          evt;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   spi_rf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, spc, sdi}), .q(pins_s));

   spi_rf_edge i_edge (
      .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .spc_s(pins_s[1]), .evt(evt));

   spi_rf_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
      .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sdi_s(pins_s[0]), .evt(evt),
      .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe));

   spi_rf_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_VAL(RST_VAL)) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: tb/test_spi_rf_slave.sv
`timescale 1ns/1ps
module test_spi_rf_slave;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic spc = 1'b1;
   logic sdi = 1'b0;
   logic sdo;
   logic sdo_oe;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [7:0] model [64];
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   spi_rf_slave i_spi_rf_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .spc(spc), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic half_wait();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic spi_bit(input logic b, input bit rd, input int idx);
      logic v;
      spc = 1'b0; sdi = b;
      half_wait();
      if (idx < 8)  check(sdo_oe == 1'b0, "R2", "oe during command", sdo_oe, 0);
      else if (rd)  check(sdo_oe == 1'b1, "R4", "oe in read data", sdo_oe, 1);
      else          check(sdo_oe == 1'b0, "R3", "oe during write data", sdo_oe, 0);
      v = sdo;
      spc = 1'b1;
      half_wait();
      if (rd && idx >= 8) check(sdo == v, "R9", "sdo held over rising edge", sdo, v);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit rd, input int base);
      for (int i = 7; i >= 0; i--) spi_bit(b[i], rd, base + (7 - i));
   endtask

   task automatic finish_xfer();
      half_wait();
      cs_n = 1'b1;
      half_wait();
      check(sdo_oe == 1'b0, "R10", "oe after select high", sdo_oe, 0);
      half_wait();
   endtask

   task automatic spi_write(input logic [5:0] addr, input bit inc, input int n,
                            input logic [7:0] d [4]);
      logic [5:0] a;
      a = addr;
      cs_n = 1'b0;
      half_wait();
      send_byte({1'b0, inc, addr}, 1'b0, 0);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], 1'b0, 8 * (k + 1));
         model[a] = d[k];
         if (inc) a = a + 6'd1;
      end
      finish_xfer();
   endtask

   task automatic spi_read(input logic [5:0] addr, input bit inc, input int n,
                           input string req);
      logic [5:0] a;
      a = addr;
      cs_n = 1'b0;
      half_wait();
      send_byte({1'b1, inc, addr}, 1'b1, 0);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(model[a]);
         tag_q.push_back(req);
         send_byte(8'h00, 1'b1, 8 * (k + 1));
         if (inc) a = a + 6'd1;
      end
      finish_xfer();
   endtask

   // scoreboard monitor: collects sdo on rising edges while enabled
   initial begin
      int n;
      logic [7:0] sh;
      logic [7:0] e;
      string t;
      n = 0; sh = '0;
      forever begin
         @(posedge spc or posedge cs_n);
         if (cs_n) n = 0;
         else if (sdo_oe) begin
            sh = {sh[6:0], sdo};
            n++;
            if (n == 8) begin
               n = 0;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", "unexpected read byte", sh, 0);
               end else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(sh == e, t, "read byte", sh, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      logic [7:0] d [4];
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: idle after reset
      check(sdo_oe == 1'b0, "R1", "oe after reset", sdo_oe, 0);
      spi_read(6'd0, 1'b0, 1, "R1");
      spi_read(6'd63, 1'b0, 1, "R1");
      // R3/R4: single byte write then read
      d = '{8'hA5, 8'h00, 8'h00, 8'h00};
      spi_write(6'd5, 1'b0, 1, d);
      spi_read(6'd5, 1'b0, 1, "R3");
      // R5: stepping multi-byte write and read
      d = '{8'h11, 8'h22, 8'h33, 8'h00};
      spi_write(6'd20, 1'b1, 3, d);
      spi_read(6'd20, 1'b1, 3, "R5");
      // R6: fixed address multi-byte
      d = '{8'h44, 8'h55, 8'h00, 8'h00};
      spi_write(6'd30, 1'b0, 2, d);
      spi_read(6'd30, 1'b0, 2, "R6");
      spi_read(6'd31, 1'b0, 1, "R6");
      // R7: wrap 63 -> 0
      d = '{8'hC1, 8'hC2, 8'hC3, 8'h00};
      spi_write(6'd62, 1'b1, 3, d);
      spi_read(6'd63, 1'b1, 2, "R7");
      // R8: partial byte dropped
      cs_n = 1'b0;
      half_wait();
      send_byte({1'b0, 1'b0, 6'd5}, 1'b0, 0);
      for (int i = 0; i < 5; i++) spi_bit(1'b0, 1'b0, 8 + i);
      finish_xfer();
      spi_read(6'd5, 1'b0, 1, "R8");
      // R2/R4: bit patterns and high address bits
      d = '{8'hFF, 8'h5A, 8'h80, 8'h01};
      spi_write(6'd40, 1'b1, 4, d);
      spi_read(6'd40, 1'b1, 4, "R4");
      spi_read(6'd41, 1'b0, 1, "R2");
      check(exp_q.size() == 0, "R4", "all read bytes seen", exp_q.size(), 0);
      report();
   end
endmodule